// File: doc/BRIEF.md
# Machine-Mode Trap and Interrupt Controller

This block is the machine-level trap unit of a small 32-bit core that runs in two privilege levels, machine (M) and user (U). It holds the six machine trap registers: status, interrupt enable, interrupt pending, cause, trap vector and exception PC. Each cycle it looks at three interrupt request lines (software, timer, external), a synchronous exception request with its code, the PC of the instruction in flight and the current privilege level. From these it decides whether a trap is taken. When one is, it drives a redirect PC and the new privilege level in the same cycle and updates its registers at the next rising edge.

A return from a trap handler is signalled on a single input. On that request the block redirects to the saved exception PC, restores the saved privilege level and pops the interrupt-enable stack. Software reads and writes the registers through a plain CSR port with a 12-bit address. The read data is combinational. A write lands at the next edge unless that cycle redirects.

Top module: `mtrap_ctrl`

## Requirements
- R1: An interrupt causes a trap only while the status global enable bit (bit 3 of 0x300) is 1 and the matching enable bit in 0x304 is 1 (bit 3 software, bit 7 timer, bit 11 external). A synchronous exception traps whatever those bits hold.
- R2: In the pending register 0x344, bit 7 follows the timer line and bit 11 follows the external line, and neither can be written. Bit 3 is set while the software line is high, is written by CSR writes, and is the only writable bit.
- R3: When several enabled interrupts are pending together, the external one (code 11) wins over software (code 3), and software wins over timer (code 7). An exception request in the same cycle wins over every interrupt.
- R4: On trap entry, the previous-enable bit (bit 7 of 0x300) takes the old global enable, the global enable clears, and the previous-privilege field (bits 12:11) takes the privilege in force: 2'b11 for M, 2'b00 for U.
- R5: On trap entry, the cause register 0x342 is written with bit 31 = 1 for an interrupt (0 for an exception) and the code in its low bits. The exception PC register 0x341 takes the trapping PC with bits 1:0 cleared.
- R6: The vector register 0x305 holds a base in bits 31:2 and a mode in bits 1:0. In mode 0 every trap goes to the base. In mode 1 an interrupt goes to base + 4 × code, and an exception still goes to the base.
- R7: A return request in a cycle without a trap redirects to the value in 0x341 and sets the output privilege to the saved previous privilege. At the next edge the global enable takes the previous-enable bit, the previous-enable bit becomes 1, and the previous-privilege field becomes U (2'b00).
- R8: After reset, all six registers read as 0 while the request lines are low.
- R9: Write masks are as follows. In 0x300 only bits 3, 7 and 12:11 are stored, and any previous-privilege value other than 2'b11 is stored as 2'b00. In 0x304 only bits 3, 7 and 11 are stored. Bit 1 of 0x305 always reads 0. Bits 1:0 of 0x341 always read 0.
- R10: A CSR write issued in a cycle that takes a trap or a return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_sw_i | input | 1 | Software interrupt request; sets the software pending bit |
| irq_timer_i | input | 1 | Timer interrupt request level |
| irq_ext_i | input | 1 | External interrupt request level |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_code_i | input | CODE_W | Exception code |
| pc_i | input | XLEN | PC of the instruction in flight |
| priv_i | input | 2 | Current privilege (2'b11 M, 2'b00 U) |
| mret_i | input | 1 | Return-from-trap request |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data, combinational |
| trap_o | output | 1 | A trap is taken this cycle |
| redirect_o | output | 1 | PC redirect this cycle (trap or return) |
| redirect_pc_o | output | XLEN | Redirect target |
| priv_o | output | 2 | Privilege level in force after this cycle |

## Verification
The trap decision, the redirect target and the output privilege depend only on the current inputs and register state, so they are valid in the cycle of the stimulus. The bench drives stimulus after a falling edge and samples these outputs a short time later, before the next rising edge. Register effects of a trap, a return or a CSR write appear only after the next rising edge. The bench therefore reads registers through the combinational read port after that edge and before the following stimulus. A priority vector stays in the state that shows the arbitration until the bench resets the block, so a taken trap never disturbs the next vector.

// File: rtl/mtrap_pkg.sv
// Package mtrap_pkg
// Shared constants and types for the machine-mode trap controller.
// Assumes a 32-bit register layout; bit positions below are fixed by it.
package mtrap_pkg;

    // CSR addresses
    localparam logic [11:0] A_STATUS = 12'h300;
    localparam logic [11:0] A_IEN    = 12'h304;
    localparam logic [11:0] A_TVEC   = 12'h305;
    localparam logic [11:0] A_EPC    = 12'h341;
    localparam logic [11:0] A_CAUSE  = 12'h342;
    localparam logic [11:0] A_IPEND  = 12'h344;

    // status field positions
    localparam int ST_GIE  = 3;
    localparam int ST_PGIE = 7;
    localparam int ST_PPL  = 11;   // low bit of the two-bit previous-privilege field

    // interrupt source bit positions in enable/pending registers
    localparam int NSRC = 3;
    localparam int SRC_SW = 0;
    localparam int SRC_TM = 1;
    localparam int SRC_EX = 2;
    localparam int SRC_BIT [NSRC] = '{3, 7, 11};

    // privilege encodings
    localparam logic [1:0] PL_U = 2'b00;
    localparam logic [1:0] PL_M = 2'b11;

    // status state held by the block
    typedef struct packed {
        logic       gie;
        logic       pgie;
        logic [1:0] ppl;
    } stat_t;

endpackage

// File: rtl/mtrap_irq_sel.sv
// Module mtrap_irq_sel
// Picks the winning interrupt among pending, individually enabled sources
// when the global enable is set. Fixed priority: external, software, timer.
// The cause code of each source equals its bit position in the pending register.
// Assumes CODE_W is wide enough to hold code 11.
module mtrap_irq_sel
    import mtrap_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic [NSRC-1:0]   pend_i,
    input  logic [NSRC-1:0]   en_i,
    input  logic              gie_i,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o
);

    // lowest priority first; later entries overwrite earlier ones
    localparam int ORDER [NSRC] = '{SRC_TM, SRC_SW, SRC_EX};

    logic [NSRC-1:0] ready;
    assign ready = pend_i & en_i & {NSRC{gie_i}};

    // scan sources from lowest to highest priority, keep the last ready one
    always_comb begin
        valid_o = 1'b0;
        code_o  = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (ready[ORDER[k]]) begin
                valid_o = 1'b1;
                code_o  = CODE_W'(SRC_BIT[ORDER[k]]);
            end
        end
    end

endmodule

// File: rtl/mtrap_target.sv
// Module mtrap_target
// Computes the trap target from the vector register. Mode bit 0 set and
// VECTORED enabled: interrupts go to base + 4*code, exceptions to base.
// Otherwise every trap goes to base.
module mtrap_target #(
    parameter int XLEN     = 32,
    parameter int CODE_W   = 5,
    parameter bit VECTORED = 1'b1
) (
    input  logic [XLEN-1:0]   tvec_i,
    input  logic              is_irq_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [XLEN-1:0]   pc_o
);

    logic [XLEN-1:0] base;
    assign base = {tvec_i[XLEN-1:2], 2'b00};

    generate
        if (VECTORED) begin : g_vec
            logic [XLEN-1:0] offs;
            // offset only for interrupts in vectored mode
            always_comb begin
                offs = '0;
                if (tvec_i[0] && is_irq_i) offs = XLEN'(code_i) << 2;
            end
            assign pc_o = base + offs;
        end else begin : g_direct
            assign pc_o = base;
        end
    endgenerate

endmodule

// File: rtl/mtrap_ctrl.sv
// Module mtrap_ctrl
// Machine-mode trap controller for an M+U core. Holds the status, enable,
// pending, vector, exception-PC and cause registers, takes traps, performs
// the return sequence and serves a combinational-read CSR port.
// Assumes XLEN = 32 for the register layout and that the core applies the
// redirect and privilege outputs in the cycle they are asserted.
module mtrap_ctrl
    import mtrap_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int CODE_W   = 5,
    parameter bit VECTORED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_sw_i,
    input  logic              irq_timer_i,
    input  logic              irq_ext_i,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [1:0]        priv_i,
    input  logic              mret_i,
    input  logic              csr_we_i,
    input  logic [11:0]       csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              trap_o,
    output logic              redirect_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [1:0]        priv_o
);

    stat_t            st_q;
    logic [NSRC-1:0]  ien_q;
    logic             swp_q;
    logic [XLEN-1:0]  tvec_q;
    logic [XLEN-1:0]  epc_q;
    logic [XLEN-1:0]  cause_q;

    logic [NSRC-1:0]  pend;
    logic             irq_valid;
    logic [CODE_W-1:0] irq_code;
    logic             is_irq;
    logic [CODE_W-1:0] trap_code;
    logic [XLEN-1:0]  tgt_pc;
    logic             ret_take;
    logic             csr_wr;

    assign pend[SRC_SW] = swp_q;
    assign pend[SRC_TM] = irq_timer_i;
    assign pend[SRC_EX] = irq_ext_i;

    mtrap_irq_sel #(.CODE_W(CODE_W)) u_sel (
        .pend_i  (pend),
        .en_i    (ien_q),
        .gie_i   (st_q.gie),
        .valid_o (irq_valid),
        .code_o  (irq_code)
    );

    assign trap_o    = exc_valid_i | irq_valid;
    assign is_irq    = ~exc_valid_i;
    assign trap_code = exc_valid_i ? exc_code_i : irq_code;

    mtrap_target #(.XLEN(XLEN), .CODE_W(CODE_W), .VECTORED(VECTORED)) u_tgt (
        .tvec_i   (tvec_q),
        .is_irq_i (is_irq),
        .code_i   (trap_code),
        .pc_o     (tgt_pc)
    );

    assign ret_take   = mret_i & ~trap_o;
    assign redirect_o = trap_o | ret_take;
    assign csr_wr     = csr_we_i & ~redirect_o;

    // redirect target and privilege after this cycle
    always_comb begin
        redirect_pc_o = '0;
        priv_o        = priv_i;
        if (trap_o) begin
            redirect_pc_o = tgt_pc;
            priv_o        = PL_M;
        end else if (ret_take) begin
            redirect_pc_o = epc_q;
            priv_o        = st_q.ppl;
        end
    end

    // status: trap push, return pop, or software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (trap_o) begin
            st_q.pgie <= st_q.gie;
            st_q.gie  <= 1'b0;
            st_q.ppl  <= (priv_i == PL_M) ? PL_M : PL_U;
        end else if (ret_take) begin
            st_q.gie  <= st_q.pgie;
            st_q.pgie <= 1'b1;
            st_q.ppl  <= PL_U;
        end else if (csr_wr && csr_addr_i == A_STATUS) begin
            st_q.gie  <= csr_wdata_i[ST_GIE];
            st_q.pgie <= csr_wdata_i[ST_PGIE];
            st_q.ppl  <= (csr_wdata_i[ST_PPL+1:ST_PPL] == PL_M) ? PL_M : PL_U;
        end
    end

    // per-source enables and software pending bit
    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ien_q[s] <= 1'b0;
                else if (csr_wr && csr_addr_i == A_IEN)
                    ien_q[s] <= csr_wdata_i[SRC_BIT[s]];
            end
        end
    endgenerate

    // software pending: request line sets it, CSR write sets or clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            swp_q <= 1'b0;
        else if (irq_sw_i)
            swp_q <= 1'b1;
        else if (csr_wr && csr_addr_i == A_IPEND)
            swp_q <= csr_wdata_i[SRC_BIT[SRC_SW]];
    end

    // vector register: bit 1 of the mode field is kept at zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            tvec_q <= '0;
        else if (csr_wr && csr_addr_i == A_TVEC)
            tvec_q <= {csr_wdata_i[XLEN-1:2], 1'b0, csr_wdata_i[0]};
    end

    // exception PC: trapping PC on entry or software write, word aligned
    always_ff @(posedge clk) begin
        if (!rst_n)
            epc_q <= '0;
        else if (trap_o)
            epc_q <= {pc_i[XLEN-1:2], 2'b00};
        else if (csr_wr && csr_addr_i == A_EPC)
            epc_q <= {csr_wdata_i[XLEN-1:2], 2'b00};
    end

    // cause: interrupt flag and code on entry, or software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else if (trap_o) begin
            cause_q                 <= '0;
            cause_q[XLEN-1]         <= is_irq;
            cause_q[CODE_W-1:0]     <= trap_code;
        end else if (csr_wr && csr_addr_i == A_CAUSE) begin
            cause_q <= csr_wdata_i;
        end
    end

    // combinational read mux
    always_comb begin
        csr_rdata_o = '0;
        unique case (csr_addr_i)
            A_STATUS: begin
                csr_rdata_o[ST_GIE]            = st_q.gie;
                csr_rdata_o[ST_PGIE]           = st_q.pgie;
                csr_rdata_o[ST_PPL+1:ST_PPL]   = st_q.ppl;
            end
            A_IEN: begin
                for (int s = 0; s < NSRC; s++) csr_rdata_o[SRC_BIT[s]] = ien_q[s];
            end
            A_IPEND: begin
                for (int s = 0; s < NSRC; s++) csr_rdata_o[SRC_BIT[s]] = pend[s];
            end
            A_TVEC:  csr_rdata_o = tvec_q;
            A_EPC:   csr_rdata_o = epc_q;
            A_CAUSE: csr_rdata_o = cause_q;
            default: csr_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/mtrap_ctrl_chk.sv
// Module mtrap_ctrl_chk
// Property checker for mtrap_ctrl, attached by bind. Observes ports and the
// status and exception-PC state across trap entry and return.
module mtrap_ctrl_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_valid_i,
    input logic            mret_i,
    input logic [XLEN-1:0] pc_i,
    input logic            trap_o,
    input logic            redirect_o,
    input logic [XLEN-1:0] redirect_pc_o,
    input logic            gie,
    input logic            pgie,
    input logic [XLEN-1:0] epc
);

    // R1: an interrupt trap needs the global enable
    p_irq_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && !exc_valid_i) |-> gie);

    // R3: an exception request always traps
    p_exc_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_i |-> trap_o);

    // R4: entry clears the global enable
    p_entry_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !gie);

    // R4: entry saves the old global enable
    p_entry_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (pgie == $past(gie)));

    // R5: entry records the trapping PC, word aligned
    p_entry_epc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (epc == {$past(pc_i[XLEN-1:2]), 2'b00}));

    // R7: a return redirects to the saved PC
    p_ret_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_i && !trap_o) |-> (redirect_o && redirect_pc_o == epc));

    // R7: a return restores the global enable
    p_ret_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_i && !trap_o) |=> (gie == $past(pgie) && pgie));

endmodule

bind mtrap_ctrl mtrap_ctrl_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .exc_valid_i   (exc_valid_i),
    .mret_i        (mret_i),
    .pc_i          (pc_i),
    .trap_o        (trap_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .gie           (st_q.gie),
    .pgie          (st_q.pgie),
    .epc           (epc_q)
);

// File: tb/tb_mtrap_ctrl.sv
// Bench for mtrap_ctrl: a priority/gating vector table, then directed tests.
module tb_mtrap_ctrl;

    localparam int XLEN = 32;
    localparam int CODE_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              irq_sw_i = 1'b0, irq_timer_i = 1'b0, irq_ext_i = 1'b0;
    logic              exc_valid_i = 1'b0;
    logic [CODE_W-1:0] exc_code_i = '0;
    logic [XLEN-1:0]   pc_i = '0;
    logic [1:0]        priv_i = 2'b00;
    logic              mret_i = 1'b0;
    logic              csr_we_i = 1'b0;
    logic [11:0]       csr_addr_i = '0;
    logic [XLEN-1:0]   csr_wdata_i = '0;
    logic [XLEN-1:0]   csr_rdata_o;
    logic              trap_o, redirect_o;
    logic [XLEN-1:0]   redirect_pc_o;
    logic [1:0]        priv_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mtrap_ctrl #(.XLEN(XLEN), .CODE_W(CODE_W)) dut (.*);

    // vector: [11:9] enables {ex,tm,sw}, [8:6] pending {ex,tm,sw}, [5] global enable, [4:0] expected code (0 = no trap)
    localparam logic [11:0] VEC [8] = '{
        12'b111_111_1_01011,
        12'b011_111_1_00011,
        12'b010_111_1_00111,
        12'b111_010_1_00111,
        12'b111_111_0_00000,
        12'b000_111_1_00000,
        12'b100_011_1_00000,
        12'b101_001_1_00011
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
        csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = d;
        tick();
        csr_we_i = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [XLEN-1:0] d);
        csr_addr_i = a;
        #1;
        d = csr_rdata_o;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [XLEN-1:0] v;
        @(negedge clk);
        do_reset();

        // R8: reset state
        rd(12'h300, v); check("R8 status", v, 0);
        rd(12'h304, v); check("R8 enable", v, 0);
        rd(12'h344, v); check("R8 pending", v, 0);
        rd(12'h305, v); check("R8 vector", v, 0);
        rd(12'h341, v); check("R8 epc", v, 0);
        rd(12'h342, v); check("R8 cause", v, 0);

        // R1/R3/R6: priority and gating table, vectored base 0x100
        for (int i = 0; i < 8; i++) begin
            logic [11:0] e;
            e = VEC[i];
            do_reset();
            priv_i = 2'b00;
            irq_ext_i = e[8]; irq_timer_i = e[7];
            wr(12'h305, 32'h101);
            wr(12'h304, {20'd0, e[11], 3'd0, e[10], 3'd0, e[9], 3'd0});
            wr(12'h344, {28'd0, e[6], 3'd0});
            wr(12'h300, {28'd0, e[5], 3'd0});
            #1;
            check("R1 R3 trap", {31'd0, trap_o}, {31'd0, (e[4:0] != 0)});
            if (e[4:0] != 0) begin
                check("R3 R6 vectored target", redirect_pc_o, 32'h100 + 4 * e[4:0]);
                check("R4 priv out", {30'd0, priv_o}, 32'd3);
            end
        end
        do_reset();
        irq_ext_i = 1'b0; irq_timer_i = 1'b0;

        // R9: write masks
        wr(12'h300, 32'hFFFF_FFFF); rd(12'h300, v); check("R9 status mask", v, 32'h1888);
        wr(12'h300, 32'h0000_0800); rd(12'h300, v); check("R9 prev priv legal", v, 0);
        wr(12'h304, 32'hFFFF_FFFF); rd(12'h304, v); check("R9 enable mask", v, 32'h888);
        wr(12'h304, 32'h0);
        wr(12'h341, 32'h1003); rd(12'h341, v); check("R9 epc align", v, 32'h1000);
        wr(12'h305, 32'hFFFF_FFFF); rd(12'h305, v); check("R9 vector mode", v, 32'hFFFF_FFFD);

        // R2: pending register
        wr(12'h344, 32'hFFFF_FFFF); rd(12'h344, v); check("R2 only sw writable", v, 32'h8);
        irq_timer_i = 1'b1; irq_ext_i = 1'b1;
        rd(12'h344, v); check("R2 lines mirrored", v, 32'h888);
        wr(12'h344, 32'h0); rd(12'h344, v); check("R2 sw cleared, lines kept", v, 32'h880);
        irq_timer_i = 1'b0; irq_ext_i = 1'b0;
        irq_sw_i = 1'b1; tick(); irq_sw_i = 1'b0;
        rd(12'h344, v); check("R2 sw line sets", v, 32'h8);
        wr(12'h344, 32'h0);

        // R1/R4/R5/R6: timer trap from U, direct mode
        wr(12'h305, 32'h200);
        wr(12'h304, 32'h80);
        wr(12'h300, 32'h8);
        priv_i = 2'b00; pc_i = 32'h1234;
        irq_timer_i = 1'b1;
        #1;
        check("R1 timer trap", {31'd0, trap_o}, 1);
        check("R6 direct target", redirect_pc_o, 32'h200);
        check("R4 priv to M", {30'd0, priv_o}, 3);
        tick();
        priv_i = 2'b11; pc_i = 32'h200;
        #1;
        check("R1 masked after entry", {31'd0, trap_o}, 0);
        rd(12'h300, v); check("R4 status after entry", v, 32'h80);
        rd(12'h342, v); check("R5 cause interrupt", v, 32'h8000_0007);
        rd(12'h341, v); check("R5 epc", v, 32'h1234);

        // R7/R10: return, with a dropped CSR write
        irq_timer_i = 1'b0;
        mret_i = 1'b1;
        csr_we_i = 1'b1; csr_addr_i = 12'h341; csr_wdata_i = 32'h9990;
        #1;
        check("R7 redirect", {31'd0, redirect_o}, 1);
        check("R7 target epc", redirect_pc_o, 32'h1234);
        check("R7 priv restored", {30'd0, priv_o}, 0);
        tick();
        mret_i = 1'b0; csr_we_i = 1'b0;
        rd(12'h300, v); check("R7 status after return", v, 32'h88);
        rd(12'h341, v); check("R10 write dropped on return", v, 32'h1234);

        // R3/R6/R10: exception beats pending timer, vectored base ignored for exceptions
        wr(12'h305, 32'h301);
        priv_i = 2'b11; pc_i = 32'h4444;
        irq_timer_i = 1'b1;
        exc_valid_i = 1'b1; exc_code_i = 5'd2;
        csr_we_i = 1'b1; csr_addr_i = 12'h342; csr_wdata_i = 32'h55;
        #1;
        check("R3 exception trap", {31'd0, trap_o}, 1);
        check("R6 exception at base", redirect_pc_o, 32'h300);
        tick();
        exc_valid_i = 1'b0; csr_we_i = 1'b0;
        rd(12'h342, v); check("R3 R10 cause exception", v, 32'h2);
        rd(12'h300, v); check("R4 prev priv M", v, 32'h1880);
        rd(12'h341, v); check("R5 epc exception", v, 32'h4444);
        irq_timer_i = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule